// File: doc/BRIEF.md
# Narrow-Bus to Wide Memory-Port Bridge

This block is a slave on a classic Wishbone bus that carries single 32-bit transfers with byte selects. It turns each transfer into a transaction on a 128-bit native memory port. That port has three independent ready/valid channels: a command channel, a write-data channel with per-byte enables, and a read-data channel. Four bus words share one wide memory word. The low bits of the bus word address pick which 32-bit lane of the wide word a transfer uses.

For a write, the bridge issues a command and then presents the bus data in the addressed lane, with the byte enables shifted into that lane. It acknowledges the bus once the memory side has accepted the data. For a read, it issues a command, waits for returned data, and hands back the addressed lane with an acknowledge in the same cycle. Only one transfer is in flight at a time. The memory side may stall any channel for as long as it likes.

Top module: `wb_wide_bridge`

## Requirements
- R1: While reset is asserted, and until a bus cycle begins after reset, `cmd_valid`, `wd_valid`, `rd_ready` and `wb_ack` are all 0.
- R2: A bus request (`wb_cyc` and `wb_stb` high while the bridge is idle) raises `cmd_valid` in the next cycle. It carries `cmd_addr` equal to the word address shifted right by 2 and `cmd_we` equal to `wb_we`.
- R3: On a write, the lane is the word address modulo 4. `wd_be` equals the 4 select bits shifted left by 4 times the lane. For example, address 1 with select 1 gives enable bit 4, and address 3 with select 0xF gives 0xF000.
- R4: A write with all select bits at 0 enables all four bytes of its lane. For example, address 4 gives `wd_be` = 0x000F.
- R5: The 32-bit write data appears in bits [32*lane+31 : 32*lane] of `wd_data`. All other bits are 0.
- R6: `wd_valid` rises only in the cycle after the command handshake, and never while `cmd_valid` is high.
- R7: `wb_ack` is high for exactly one cycle on a write: the cycle after the write-data handshake.
- R8: On a read, `rd_ready` rises after the command handshake. In the cycle where `rd_valid` is high, `wb_dat_r` equals bits [32*lane+31 : 32*lane] of `rd_data` and `wb_ack` is high in that same cycle.
- R9: A request still held on the bus during its acknowledge cycle does not start a new transaction. No new command appears until the bus request is presented again.
- R10: While `cmd_ready` or `wd_ready` is held low, the offered command or write data stays valid and unchanged, and no acknowledge is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc | input | 1 | Bus cycle in progress |
| wb_stb | input | 1 | Transfer strobe |
| wb_we | input | 1 | 1 = write, 0 = read |
| wb_adr | input | 30 | Bus word address |
| wb_sel | input | 4 | Byte selects |
| wb_dat_w | input | 32 | Write data from master |
| wb_dat_r | output | 32 | Read data to master |
| wb_ack | output | 1 | Transfer acknowledge |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted |
| cmd_we | output | 1 | Command is a write |
| cmd_addr | output | 28 | Wide-word address |
| wd_valid | output | 1 | Write data offered |
| wd_ready | input | 1 | Write data accepted |
| wd_data | output | 128 | Wide write word |
| wd_be | output | 16 | Byte enables of wide write word |
| rd_valid | input | 1 | Read data returned |
| rd_ready | output | 1 | Bridge waits for read data |
| rd_data | input | 128 | Wide read word |

## Verification
The bench sweeps every select pattern over eight addresses. That covers all four lanes and the wrap from address 3 to address 4, with varying stalls on each channel. A bridge that shifted by the wrong amount would put enables or data in a neighbouring lane. One that passed an empty select straight through would offer a write that changes nothing.

Reads are checked for every lane against a wide word whose lanes all differ, so a wrong lane choice returns a visible mismatch. The master keeps its strobe high through each acknowledge cycle. A bridge without a guard after the acknowledge would start a phantom second command, and a late acknowledge would be counted as a double pulse.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CMD   = 2'd1,
    ST_WDATA = 2'd2,
    ST_RDATA = 2'd3
  } wbb_state_e;
endpackage

// File: rtl/wbb_rst_sync.sv
module wbb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wbb_lane_pack.sv
module wbb_lane_pack #(
  parameter int WB_DW  = 32,
  parameter int MEM_DW = 128,
  localparam int SEL_W     = WB_DW / 8,
  localparam int LANES     = MEM_DW / WB_DW,
  localparam int LANE_BITS = $clog2(LANES),
  localparam int BE_W      = MEM_DW / 8
) (
  input  logic [LANE_BITS-1:0] lane,
  input  logic [SEL_W-1:0]     sel,
  input  logic [WB_DW-1:0]     dat,
  output logic [MEM_DW-1:0]    wide_dat,
  output logic [BE_W-1:0]      wide_be
);
  // An empty select means the whole word is written.
  logic [SEL_W-1:0] sel_eff;
  assign sel_eff = (sel == '0) ? {SEL_W{1'b1}} : sel;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit = (lane == LANE_BITS'(g));
    assign wide_be[g*SEL_W +: SEL_W]  = hit ? sel_eff : '0;
    assign wide_dat[g*WB_DW +: WB_DW] = hit ? dat : '0;
  end
endmodule

// File: rtl/wbb_lane_pick.sv
module wbb_lane_pick #(
  parameter int WB_DW  = 32,
  parameter int MEM_DW = 128,
  localparam int LANES     = MEM_DW / WB_DW,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  logic [LANE_BITS-1:0] lane,
  input  logic [MEM_DW-1:0]    wide_dat,
  output logic [WB_DW-1:0]     dat
);
  logic [WB_DW-1:0] slice [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_slice
    assign slice[g] = wide_dat[g*WB_DW +: WB_DW];
  end

  assign dat = slice[lane];
endmodule

// File: rtl/wbb_ctrl.sv
module wbb_ctrl
  import wbb_pkg::*;
#(
  parameter int WB_AW  = 30,
  parameter int WB_DW  = 32,
  parameter int MEM_DW = 128,
  localparam int SEL_W     = WB_DW / 8,
  localparam int LANES     = MEM_DW / WB_DW,
  localparam int LANE_BITS = $clog2(LANES),
  localparam int MEM_AW    = WB_AW - LANE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wb_cyc,
  input  logic                 wb_stb,
  input  logic                 wb_we,
  input  logic [WB_AW-1:0]     wb_adr,
  input  logic [SEL_W-1:0]     wb_sel,
  input  logic [WB_DW-1:0]     wb_dat_w,
  input  logic                 cmd_ready,
  input  logic                 wd_ready,
  input  logic                 rd_valid,
  output logic                 cmd_valid,
  output logic                 cmd_we,
  output logic [MEM_AW-1:0]    cmd_addr,
  output logic                 wd_valid,
  output logic                 rd_ready,
  output logic                 wb_ack,
  output logic [LANE_BITS-1:0] lane,
  output logic [SEL_W-1:0]     sel,
  output logic [WB_DW-1:0]     dat
);
  wbb_state_e state_q, state_d;
  logic       wack_q, wack_d;
  logic       start;

  logic [MEM_AW-1:0]    addr_q;
  logic [LANE_BITS-1:0] lane_q;
  logic                 we_q;
  logic [SEL_W-1:0]     sel_q;
  logic [WB_DW-1:0]     dat_q;

  // The write-ack cycle blocks a restart while the master still holds stb.
  assign start = (state_q == ST_IDLE) && wb_cyc && wb_stb && !wack_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_CMD;
      ST_CMD:   if (cmd_ready) state_d = we_q ? ST_WDATA : ST_RDATA;
      ST_WDATA: if (wd_ready) state_d = ST_IDLE;
      ST_RDATA: if (rd_valid) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign wack_d = (state_q == ST_WDATA) && wd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wack_q  <= wack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lane_q <= '0;
      we_q   <= 1'b0;
      sel_q  <= '0;
      dat_q  <= '0;
    end else if (start) begin
      addr_q <= wb_adr[WB_AW-1:LANE_BITS];
      lane_q <= wb_adr[LANE_BITS-1:0];
      we_q   <= wb_we;
      sel_q  <= wb_sel;
      dat_q  <= wb_dat_w;
    end
  end

  assign cmd_valid = (state_q == ST_CMD);
  assign cmd_we    = we_q;
  assign cmd_addr  = addr_q;
  assign wd_valid  = (state_q == ST_WDATA);
  assign rd_ready  = (state_q == ST_RDATA);
  assign wb_ack    = wack_q || ((state_q == ST_RDATA) && rd_valid);
  assign lane      = lane_q;
  assign sel       = sel_q;
  assign dat       = dat_q;

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack |=> !wb_ack);

  assert_wd_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && wd_ready) |=> wb_ack);

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_we)));

  assert_wd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && !wd_ready) |=> (wd_valid && !wb_ack));

  assert_wd_after_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_valid) |-> $past(cmd_valid && cmd_ready));

  assert_one_channel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, wd_valid, rd_ready}));
endmodule

// File: rtl/wb_wide_bridge.sv
module wb_wide_bridge #(
  parameter int WB_AW  = 30,
  parameter int WB_DW  = 32,
  parameter int MEM_DW = 128,
  localparam int SEL_W     = WB_DW / 8,
  localparam int LANES     = MEM_DW / WB_DW,
  localparam int LANE_BITS = $clog2(LANES),
  localparam int MEM_AW    = WB_AW - LANE_BITS,
  localparam int BE_W      = MEM_DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_cyc,
  input  logic              wb_stb,
  input  logic              wb_we,
  input  logic [WB_AW-1:0]  wb_adr,
  input  logic [SEL_W-1:0]  wb_sel,
  input  logic [WB_DW-1:0]  wb_dat_w,
  output logic [WB_DW-1:0]  wb_dat_r,
  output logic              wb_ack,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_we,
  output logic [MEM_AW-1:0] cmd_addr,
  output logic              wd_valid,
  input  logic              wd_ready,
  output logic [MEM_DW-1:0] wd_data,
  output logic [BE_W-1:0]   wd_be,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [MEM_DW-1:0] rd_data
);
  logic                 rst_n_s;
  logic [LANE_BITS-1:0] lane;
  logic [SEL_W-1:0]     sel;
  logic [WB_DW-1:0]     dat;

  wbb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  wbb_ctrl #(.WB_AW(WB_AW), .WB_DW(WB_DW), .MEM_DW(MEM_DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_sel(wb_sel), .wb_dat_w(wb_dat_w),
    .cmd_ready(cmd_ready), .wd_ready(wd_ready), .rd_valid(rd_valid),
    .cmd_valid(cmd_valid), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
    .wd_valid(wd_valid), .rd_ready(rd_ready), .wb_ack(wb_ack),
    .lane(lane), .sel(sel), .dat(dat)
  );

  wbb_lane_pack #(.WB_DW(WB_DW), .MEM_DW(MEM_DW)) u_pack (
    .lane(lane), .sel(sel), .dat(dat), .wide_dat(wd_data), .wide_be(wd_be)
  );

  wbb_lane_pick #(.WB_DW(WB_DW), .MEM_DW(MEM_DW)) u_pick (
    .lane(lane), .wide_dat(rd_data), .dat(wb_dat_r)
  );

  assert_be_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    wd_valid |-> (wd_be != '0));

  assert_be_width_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    wd_valid |-> ($countones(wd_be) <= SEL_W));

  assert_read_ack_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_valid && rd_ready) |-> wb_ack);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n_s |-> !(cmd_valid || wd_valid || rd_ready || wb_ack));
endmodule

// File: tb/wb_wide_bridge_tb.sv
module wb_wide_bridge_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n;
  logic         wb_cyc, wb_stb, wb_we;
  logic [29:0]  wb_adr;
  logic [3:0]   wb_sel;
  logic [31:0]  wb_dat_w, wb_dat_r;
  logic         wb_ack;
  logic         cmd_valid, cmd_ready, cmd_we;
  logic [27:0]  cmd_addr;
  logic         wd_valid, wd_ready;
  logic [127:0] wd_data;
  logic [15:0]  wd_be;
  logic         rd_valid, rd_ready;
  logic [127:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  wb_wide_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_sel(wb_sel), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data), .wd_be(wd_be),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet(input string req);
    chk(!cmd_valid && !wd_valid && !rd_ready && !wb_ack, req,
        {cmd_valid, wd_valid, rd_ready, wb_ack}, 0);
  endtask

  // Master holds stb through the acknowledge cycle and drops it after the edge.
  task automatic release_bus();
    @(posedge clk);
    #1;
    wb_cyc = 1'b0;
    wb_stb = 1'b0;
    rd_valid = 1'b0;
  endtask

  task automatic do_write(input logic [29:0] adr, input logic [3:0] sel,
                          input logic [31:0] dat, input int cs, input int ws);
    logic [1:0]   ln;
    logic [3:0]   se;
    logic [15:0]  ebe;
    logic [127:0] edat;
    ln   = adr[1:0];
    se   = (sel == 4'd0) ? 4'hF : sel;
    ebe  = 16'(se) << (4 * ln);
    edat = 128'(dat) << (32 * ln);
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b1;
    wb_adr = adr; wb_sel = sel; wb_dat_w = dat;
    @(negedge clk);
    chk(cmd_valid && cmd_we && cmd_addr == adr[29:2], "R2", {cmd_valid, cmd_we, cmd_addr},
        {2'b11, adr[29:2]});
    for (int i = 0; i < cs; i++) begin
      @(negedge clk);
      chk(cmd_valid && !wd_valid && !wb_ack && cmd_addr == adr[29:2], "R10",
          {cmd_valid, wd_valid, wb_ack}, 3'b100);
    end
    chk(!wd_valid, "R6", wd_valid, 0);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    chk(wd_valid && !cmd_valid, "R6", {wd_valid, cmd_valid}, 2'b10);
    if (sel == 4'd0) chk(wd_be == ebe, "R4", wd_be, ebe);
    else             chk(wd_be == ebe, "R3", wd_be, ebe);
    chk(wd_data == edat, "R5", wd_data, edat);
    for (int i = 0; i < ws; i++) begin
      @(negedge clk);
      chk(wd_valid && !wb_ack && wd_be == ebe && wd_data == edat, "R10",
          {wd_valid, wb_ack}, 2'b10);
    end
    wd_ready = 1'b1;
    @(negedge clk);
    wd_ready = 1'b0;
    chk(wb_ack && !wd_valid, "R7", {wb_ack, wd_valid}, 2'b10);
    release_bus();
    @(negedge clk);
    chk(!wb_ack, "R7", wb_ack, 0);
    chk(!cmd_valid, "R9", cmd_valid, 0);
  endtask

  task automatic do_read(input logic [29:0] adr, input int cs, input int rs,
                         input logic [127:0] word);
    logic [31:0] edat;
    edat = word[32*adr[1:0] +: 32];
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b0;
    wb_adr = adr; wb_sel = 4'hF; wb_dat_w = 32'h0;
    @(negedge clk);
    chk(cmd_valid && !cmd_we && cmd_addr == adr[29:2], "R2", {cmd_valid, cmd_we, cmd_addr},
        {2'b10, adr[29:2]});
    for (int i = 0; i < cs; i++) begin
      @(negedge clk);
      chk(cmd_valid && !rd_ready && !wb_ack, "R10", {cmd_valid, rd_ready, wb_ack}, 3'b100);
    end
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    chk(rd_ready && !wb_ack, "R8", {rd_ready, wb_ack}, 2'b10);
    for (int i = 0; i < rs; i++) begin
      @(negedge clk);
      chk(rd_ready && !wb_ack, "R8", {rd_ready, wb_ack}, 2'b10);
    end
    rd_data  = word;
    rd_valid = 1'b1;
    #0.5;
    chk(wb_ack, "R8", wb_ack, 1);
    chk(wb_dat_r == edat, "R8", wb_dat_r, edat);
    release_bus();
    @(negedge clk);
    chk(!wb_ack && !rd_ready && !cmd_valid, "R9", {wb_ack, rd_ready, cmd_valid}, 0);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
    wb_adr = '0; wb_sel = '0; wb_dat_w = '0;
    cmd_ready = 1'b0; wd_ready = 1'b0; rd_valid = 1'b0; rd_data = '0;
    repeat (3) @(negedge clk);
    quiet("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    quiet("R1");

    for (int a = 0; a < 8; a++) begin
      for (int s = 0; s < 16; s++) begin
        do_write(30'(a) | 30'h2A50, 4'(s), 32'hC0DE0000 | 32'(a * 16 + s), a % 3, s % 2);
      end
    end
    do_write(30'h3FFFFFFF, 4'h1, 32'hFEED_BEEF, 0, 0);
    do_write(30'd4, 4'h0, 32'hAAAAAAAA, 2, 3);

    for (int a = 0; a < 8; a++) begin
      logic [127:0] w;
      for (int k = 0; k < 4; k++) w[32*k +: 32] = 32'h1111_0000 * (k + 1) ^ 32'(a * 7 + k);
      do_read(30'(a) | 30'h1230, a % 2, a % 4, w);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule